// File: doc/BRIEF.md
# Isochronous Packet Header Builder with Presentation Stamp

This block builds the two leading header quadlets of an outgoing common isochronous packet. Software programs two 32-bit configuration words through a small register port. The first word supplies the block size, the fraction code, the padding count and the time-stamp flag. The second word supplies the format code and the 24-bit format-dependent field. For each packet the transmitter pulses a header request, and one cycle later the block presents both quadlets together with a one-cycle valid strobe. The source node identifier and the data block count come from inputs on every request.

When the stamp enable input is high, the low 16 bits of the second quadlet are replaced on each packet. They carry a presentation time stamp if a rising edge arrived on the external frame sync input since the previous header. They carry 0xFFFF if no such edge arrived. The frame sync input is asynchronous, so it passes through a flop synchronizer before its rising edges are detected. The first detected edge after a header latches the 16-bit cycle time input. Further edges before the next header leave that stamp unchanged. An edge detected in the same cycle as a header request is held over for the following packet.

Top module: `cip_hdr_gen`

## Requirements
- R1: After reset, both configuration words read 0x00000000 and hdr_valid is low.
- R2: A write to byte offset 0x0 sets configuration word A, and a write to byte offset 0x4 sets configuration word B. All 32 bits are written and read back on reg_rdata in the same cycle. Any other offset reads 0 and a write to it changes neither word.
- R3: hdr_q1 is built as follows: bits 31..30 are 00, bits 29..24 are src_id, bits 23..10 are word A bits 23..10, bits 9..8 are 00 and bits 7..0 are dbc. src_id and dbc are sampled in the request cycle.
- R4: With stamp_en low, hdr_q2 is built as follows: bits 31..30 are 10, bits 29..24 are word B bits 29..24 and bits 23..0 are word B bits 23..0.
- R5: With stamp_en high and a frame sync rising edge since the previous header, hdr_q2 bits 15..0 hold the latched cycle time. Bits 31..16 are formed as in R4.
- R6: With stamp_en high and no frame sync rising edge since the previous header, hdr_q2 bits 15..0 are 0xFFFF.
- R7: Only the first detected edge after a header latches cyc_time. Later edges before the next header do not change the stamp.
- R8: A frame sync edge detected in the cycle of a header request does not affect that header. It is pending, with its own latched cycle time, for the next header.
- R9: hdr_valid is high for exactly one cycle, in the cycle after each cycle in which hdr_req is high.
- R10: A header request clears the pending edge. The next header with no new edge carries 0xFFFF when stamp_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| stamp_en | input | 1 | Replace low 16 bits of quadlet 2 with the stamp or 0xFFFF |
| fsync_in | input | 1 | Asynchronous frame sync |
| cyc_time | input | 16 | Cycle time value latched on a frame sync edge |
| src_id | input | 6 | Source node identifier for quadlet 1 |
| dbc | input | 8 | Data block count for quadlet 1 |
| hdr_req | input | 1 | Header request, one pulse per packet |
| hdr_valid | output | 1 | Quadlets valid, one cycle after a request |
| hdr_q1 | output | 32 | Header quadlet 1 |
| hdr_q2 | output | 32 | Header quadlet 2 |

## Verification
The hardest case to reach is R8, where a frame sync edge is detected in the same cycle that a header request is taken. The detection point lies two synchronizer stages behind the input pin. The bench raises fsync_in on a falling clock edge, waits exactly two rising edges, and then drives hdr_req for the following edge. The header it receives must still show 0xFFFF. The next header must show the cycle time present at that edge, even though cyc_time has changed in between. A second directed case sends two sync pulses with different cycle times between headers, which checks that only the first one is kept.

// File: rtl/cip_hdr_pkg.sv
package cip_hdr_pkg;

   localparam int unsigned QUAD_W     = 32;
   localparam int unsigned STAMP_BITS = 16;
   localparam int unsigned SID_BITS   = 6;
   localparam int unsigned DBC_BITS   = 8;

   // fixed tags in bits 31..30
   localparam logic [1:0] Q1_TAG = 2'b00;
   localparam logic [1:0] Q2_TAG = 2'b10;

   // value sent when no frame sync edge was seen
   localparam logic [STAMP_BITS-1:0] NO_STAMP = '1;

   // quadlet 1 configuration field span (size, fraction, pad, ts flag)
   localparam int unsigned Q1_CFG_HI = 23;
   localparam int unsigned Q1_CFG_LO = 10;

   function automatic logic [QUAD_W-1:0] pack_q1(
      input logic [QUAD_W-1:0]   cfg,
      input logic [SID_BITS-1:0] sid,
      input logic [DBC_BITS-1:0] cnt
   );
      logic [QUAD_W-1:0] q;
      q        = '0;
      q[31:30] = Q1_TAG;
      q[29:24] = sid;
      q[Q1_CFG_HI:Q1_CFG_LO] = cfg[Q1_CFG_HI:Q1_CFG_LO];
      q[7:0]   = cnt;
      return q;
   endfunction

   function automatic logic [QUAD_W-1:0] pack_q2(
      input logic [QUAD_W-1:0]     cfg,
      input logic                  use_stamp,
      input logic                  have_edge,
      input logic [STAMP_BITS-1:0] stamp
   );
      logic [QUAD_W-1:0] q;
      q        = cfg;
      q[31:30] = Q2_TAG;
      if (use_stamp) begin
         q[STAMP_BITS-1:0] = have_edge ? stamp : NO_STAMP;
      end
      return q;
   endfunction

endpackage

// File: rtl/cip_cfg_regs.sv
module cip_cfg_regs #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [REG_W-1:0]  cfg_a,
   output logic [REG_W-1:0]  cfg_b
);

   localparam int unsigned NUM_REGS = 2;
   localparam int unsigned STRIDE   = REG_W / 8;

   if (ADDR_W < 3) begin : g_addr_chk
      $error("cip_cfg_regs: ADDR_W must be at least 3");
   end
   if (REG_W != 32) begin : g_width_chk
      $error("cip_cfg_regs: REG_W must be 32");
   end

   logic [REG_W-1:0]    regs [NUM_REGS];
   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(i * STRIDE);

      assign hit[i] = (addr == OFFSET);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
         end else if (wr_en && hit[i]) begin
            regs[i] <= wdata;
         end
      end

      // R2
      write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit[i]) |=> (regs[i] == $past(wdata)));

      // R2
      no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!(wr_en && hit[i])) |=> $stable(regs[i]));
   end

   always_comb begin
      rdata = '0;
      for (int j = 0; j < NUM_REGS; j++) begin
         if (hit[j]) rdata = regs[j];
      end
   end

   assign cfg_a = regs[0];
   assign cfg_b = regs[1];

endmodule

// File: rtl/cip_fsync_stamp.sv
module cip_fsync_stamp #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAMP_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync_in,
   input  logic [STAMP_W-1:0] cyc_time,
   input  logic               hdr_take,
   output logic               pending,
   output logic [STAMP_W-1:0] stamp
);

   if (SYNC_STAGES < 2) begin : g_sync_chk
      $error("cip_fsync_stamp: SYNC_STAGES must be at least 2");
   end
   if (STAMP_W < 1) begin : g_stamp_chk
      $error("cip_fsync_stamp: STAMP_W must be positive");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_prev;
   logic                   edge_seen;
   logic                   capture;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= fsync_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_prev <= 1'b0;
      else        sync_prev <= sync_q[SYNC_STAGES-1];
   end

   assign edge_seen = sync_q[SYNC_STAGES-1] & ~sync_prev;

   // latch on the first edge of a packet interval; a header taken in the
   // same cycle opens a new interval, so the edge belongs to it
   assign capture = edge_seen & (~pending | hdr_take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         stamp   <= '0;
      end else begin
         if (edge_seen)     pending <= 1'b1;
         else if (hdr_take) pending <= 1'b0;
         if (capture)       stamp   <= cyc_time;
      end
   end

   // R8
   edge_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> pending);

   // R10
   take_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_take && !edge_seen) |=> !pending);

   // R7
   stamp_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !hdr_take) |=> $stable(stamp));

   // R5
   stamp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen && !pending) |=> (stamp == $past(cyc_time)));

endmodule

// File: rtl/cip_hdr_pack.sv
module cip_hdr_pack
   import cip_hdr_pkg::*;
#(
   parameter int unsigned STAMP_W = 16,
   parameter int unsigned SID_W   = 6,
   parameter int unsigned DBC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_req,
   input  logic [QUAD_W-1:0]  cfg_a,
   input  logic [QUAD_W-1:0]  cfg_b,
   input  logic               stamp_en,
   input  logic               pending,
   input  logic [STAMP_W-1:0] stamp,
   input  logic [SID_W-1:0]   src_id,
   input  logic [DBC_W-1:0]   dbc,
   output logic               hdr_valid,
   output logic [QUAD_W-1:0]  hdr_q1,
   output logic [QUAD_W-1:0]  hdr_q2
);

   if (STAMP_W != STAMP_BITS) begin : g_stamp_chk
      $error("cip_hdr_pack: STAMP_W must match the 16-bit stamp slot");
   end
   if (SID_W != SID_BITS) begin : g_sid_chk
      $error("cip_hdr_pack: SID_W must be 6");
   end
   if (DBC_W != DBC_BITS) begin : g_dbc_chk
      $error("cip_hdr_pack: DBC_W must be 8");
   end

   logic [QUAD_W-1:0] q1_next;
   logic [QUAD_W-1:0] q2_next;
   logic              unused_cfg;

   assign unused_cfg = ^{cfg_a[31:24], cfg_a[9:0]};

   assign q1_next = pack_q1(cfg_a, src_id, dbc);
   assign q2_next = pack_q2(cfg_b, stamp_en, pending, stamp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_valid <= 1'b0;
         hdr_q1    <= '0;
         hdr_q2    <= '0;
      end else begin
         hdr_valid <= hdr_req;
         if (hdr_req) begin
            hdr_q1 <= q1_next;
            hdr_q2 <= q2_next;
         end
      end
   end

   // R9
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_req |=> hdr_valid);

   // R9
   valid_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_req |=> !hdr_valid);

   // R6
   no_edge_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_req && stamp_en && !pending) |=> (hdr_q2[15:0] == 16'hFFFF));

   // R4
   plain_fdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_req && !stamp_en) |=> (hdr_q2[23:0] == $past(cfg_b[23:0])));

endmodule

// File: rtl/cip_hdr_gen.sv
module cip_hdr_gen
   import cip_hdr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAMP_W     = 16,
   parameter int unsigned SID_W       = 6,
   parameter int unsigned DBC_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               stamp_en,
   input  logic               fsync_in,
   input  logic [STAMP_W-1:0] cyc_time,
   input  logic [SID_W-1:0]   src_id,
   input  logic [DBC_W-1:0]   dbc,
   input  logic               hdr_req,
   output logic               hdr_valid,
   output logic [31:0]        hdr_q1,
   output logic [31:0]        hdr_q2
);

   logic [QUAD_W-1:0]  cfg_a;
   logic [QUAD_W-1:0]  cfg_b;
   logic               pending;
   logic [STAMP_W-1:0] stamp;

   cip_cfg_regs #(
      .ADDR_W (ADDR_W),
      .REG_W  (QUAD_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .cfg_a  (cfg_a),
      .cfg_b  (cfg_b)
   );

   cip_fsync_stamp #(
      .SYNC_STAGES (SYNC_STAGES),
      .STAMP_W     (STAMP_W)
   ) u_stamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync_in (fsync_in),
      .cyc_time (cyc_time),
      .hdr_take (hdr_req),
      .pending  (pending),
      .stamp    (stamp)
   );

   cip_hdr_pack #(
      .STAMP_W (STAMP_W),
      .SID_W   (SID_W),
      .DBC_W   (DBC_W)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .hdr_req   (hdr_req),
      .cfg_a     (cfg_a),
      .cfg_b     (cfg_b),
      .stamp_en  (stamp_en),
      .pending   (pending),
      .stamp     (stamp),
      .src_id    (src_id),
      .dbc       (dbc),
      .hdr_valid (hdr_valid),
      .hdr_q1    (hdr_q1),
      .hdr_q2    (hdr_q2)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !hdr_valid);

endmodule

// File: tb/cip_hdr_gen_tb.sv
module cip_hdr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        stamp_en = 1'b0;
   logic        fsync_in = 1'b0;
   logic [15:0] cyc_time = '0;
   logic [5:0]  src_id = '0;
   logic [7:0]  dbc = '0;
   logic        hdr_req = 1'b0;
   logic        hdr_valid;
   logic [31:0] hdr_q1;
   logic [31:0] hdr_q2;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [31:0] cfg_a_m = '0;
   logic [31:0] cfg_b_m = '0;

   always #5 clk = ~clk;

   cip_hdr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stamp_en(stamp_en),
      .fsync_in(fsync_in), .cyc_time(cyc_time), .src_id(src_id), .dbc(dbc),
      .hdr_req(hdr_req), .hdr_valid(hdr_valid), .hdr_q1(hdr_q1), .hdr_q2(hdr_q2)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // one header; checks the R9 strobe shape and returns both quadlets
   task automatic take_header(output logic [31:0] q1, output logic [31:0] q2);
      @(negedge clk);
      hdr_req = 1'b1;
      @(negedge clk);
      hdr_req = 1'b0;
      check("R9 valid after request", {31'd0, hdr_valid}, 32'd1);
      q1 = hdr_q1; q2 = hdr_q2;
      @(negedge clk);
      check("R9 valid one cycle only", {31'd0, hdr_valid}, 32'd0);
   endtask

   task automatic sync_pulse;
      @(negedge clk);
      fsync_in = 1'b1;
      repeat (4) @(negedge clk);
      fsync_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_q2(input logic [31:0] cfg, input logic use_st,
                                          input logic edge_ok, input logic [15:0] st);
      logic [31:0] q;
      q = {2'b10, cfg[29:0]};
      if (use_st) q[15:0] = edge_ok ? st : 16'hFFFF;
      return q;
   endfunction

   task automatic t_reset;
      logic [31:0] d;
      check("R1 valid low after reset", {31'd0, hdr_valid}, 32'd0);
      reg_read(4'h0, d); check("R1 word A reset", d, 32'h0);
      reg_read(4'h4, d); check("R1 word B reset", d, 32'h0);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      reg_write(4'h0, 32'hDEADBEEF); cfg_a_m = 32'hDEADBEEF;
      reg_write(4'h4, 32'h12345678); cfg_b_m = 32'h12345678;
      reg_read(4'h0, d); check("R2 word A readback", d, cfg_a_m);
      reg_read(4'h4, d); check("R2 word B readback", d, cfg_b_m);
      reg_write(4'h8, 32'hFFFFFFFF);
      reg_read(4'h8, d); check("R2 unmapped reads zero", d, 32'h0);
      reg_read(4'h0, d); check("R2 word A untouched", d, cfg_a_m);
      reg_read(4'h4, d); check("R2 word B untouched", d, cfg_b_m);
   endtask

   task automatic t_q1_layout;
      logic [31:0] q1, q2;
      reg_write(4'h0, 32'hA5A5A5A5); cfg_a_m = 32'hA5A5A5A5;
      src_id = 6'h2B; dbc = 8'hC3;
      take_header(q1, q2);
      check("R3 quadlet 1 layout", q1, {2'b00, 6'h2B, cfg_a_m[23:10], 2'b00, 8'hC3});
      src_id = 6'h01; dbc = 8'h00;
      take_header(q1, q2);
      check("R3 quadlet 1 second pattern", q1, {2'b00, 6'h01, cfg_a_m[23:10], 2'b00, 8'h00});
   endtask

   task automatic t_plain_fdf;
      logic [31:0] q1, q2;
      stamp_en = 1'b0;
      reg_write(4'h4, 32'hFF9ABCDE); cfg_b_m = 32'hFF9ABCDE;
      cyc_time = 16'h5555;
      sync_pulse();
      take_header(q1, q2);
      check("R4 fdf passes with stamp off", q2, {2'b10, cfg_b_m[29:0]});
   endtask

   task automatic t_stamp_and_clear;
      logic [31:0] q1, q2;
      stamp_en = 1'b1;
      cyc_time = 16'hBEEF;
      sync_pulse();
      cyc_time = 16'h0F0F;
      take_header(q1, q2);
      check("R5 stamp inserted", q2, exp_q2(cfg_b_m, 1'b1, 1'b1, 16'hBEEF));
      take_header(q1, q2);
      check("R10 pending cleared by header", q2, exp_q2(cfg_b_m, 1'b1, 1'b0, 16'h0));
      take_header(q1, q2);
      check("R6 no edge gives all ones", q2[15:0], 32'h0000FFFF);
   endtask

   task automatic t_first_edge;
      logic [31:0] q1, q2;
      stamp_en = 1'b1;
      cyc_time = 16'h1111;
      sync_pulse();
      cyc_time = 16'h2222;
      sync_pulse();
      take_header(q1, q2);
      check("R7 first edge kept", q2, exp_q2(cfg_b_m, 1'b1, 1'b1, 16'h1111));
   endtask

   task automatic t_same_cycle;
      logic [31:0] q1, q2;
      stamp_en = 1'b1;
      cyc_time = 16'h3333;
      @(negedge clk);
      fsync_in = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      hdr_req = 1'b1;
      @(negedge clk);
      hdr_req = 1'b0;
      check("R8 valid for colliding request", {31'd0, hdr_valid}, 32'd1);
      check("R8 colliding edge not in this header", hdr_q2, exp_q2(cfg_b_m, 1'b1, 1'b0, 16'h0));
      cyc_time = 16'h4444;
      repeat (3) @(negedge clk);
      fsync_in = 1'b0;
      repeat (4) @(negedge clk);
      take_header(q1, q2);
      check("R8 colliding edge used next", q2, exp_q2(cfg_b_m, 1'b1, 1'b1, 16'h3333));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_q1_layout();
      t_plain_fdf();
      t_stamp_and_clear();
      t_first_edge();
      t_same_cycle();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule